// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block gives a streaming application lossless transfers over a link that has no backpressure wire between the two ends. On the transmit side, application flits enter a store-and-forward buffer. They are cut into packets of at most `DCU` data flits, and each packet is preceded by one control flit. On the receive side, control flits are parsed, payload flits are queued in a receive buffer for the local application, and the credit updates carried back by the peer are applied to the transmitter's credit counter.

Every flit the local application drains from the receive buffer becomes a credit owed to the peer. These credits ride in the next outgoing control flit. When no data packet can leave, they go out in a credit-only packet instead. Each direction runs on its own, so the block serves both one-way and two-way traffic. All four streams are `W`-bit valid/ready interfaces, and `W` must exceed 28.

Top module: `link_credit_fc`

## Requirements
- R1: A control flit carries its header in the top 28 bits, from the MSB down: length in data flits [W-1:W-12], start flag [W-13], end flag [W-14], credit-only flag [W-15], a reserved bit [W-16] that is zero, and a 12-bit credit count [W-17:W-28]. All lower bits are zero.
- R2: Every packet on the link is one control flit followed by exactly `length` data flits. A data packet has 1 to `DCU` data flits.
- R3: Store-and-forward: a data packet's control flit is issued only after all of that packet's flits have been accepted from the application.
- R4: A message of N flits, closed by `app_tx_last_i`, is sent as packets of `DCU` flits followed by one shorter remainder. The start flag is set only on the first packet of the message, and the end flag only on its last packet.
- R5: The transmitter's credit starts at `RX_DEPTH`. A data packet leaves only when the credit covers its length. If the peer drains nothing, exactly `RX_DEPTH` data flits cross the link and then link valid stays low.
- R6: Credit counts received from the peer restore the transmitter's credit, so traffic of any length is fully delivered.
- R7: When locally drained credits are pending and no data packet is launched, a credit-only packet goes out with length 0, start = end = 0 and credit-only = 1. The credit counts sent in all control flits add up to the flits the application drained.
- R8: Received payload flits reach the application in order. `app_rx_last_o` is set on the final flit of every packet that had the end flag.
- R9: While `link_tx_valid_o` is high and `link_tx_ready_i` is low, the valid and the flit stay unchanged in the next cycle.
- R10: After reset, both output valids are low, and `app_tx_ready_o` and `link_rx_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| app_tx_data_i | input | W | Application flit to send |
| app_tx_valid_i | input | 1 | Application flit valid |
| app_tx_last_i | input | 1 | Flit closes a message |
| app_tx_ready_o | output | 1 | Transmit buffer can take a flit |
| link_tx_data_o | output | W | Flit toward the link |
| link_tx_valid_o | output | 1 | Link flit valid |
| link_tx_ready_i | input | 1 | Link accepts the flit |
| link_rx_data_i | input | W | Flit from the link |
| link_rx_valid_i | input | 1 | Incoming flit valid |
| link_rx_ready_o | output | 1 | Receiver accepts the flit |
| app_rx_data_o | output | W | Received payload flit |
| app_rx_valid_o | output | 1 | Received flit valid |
| app_rx_last_o | output | 1 | Flit ends a message |
| app_rx_ready_i | input | 1 | Application takes the flit |

## Verification
A wrong credit count shows at the link within one packet. Too many credits lets more than `RX_DEPTH` data flits through while the receiver is stalled. Too few credits, or a lost credit update, leaves data stranded, so fewer flits reach the application than entered it. A corrupt segment counter or start/end register shows up in the very next control flit as a length or flag that differs from the message split. A fault in the receiver's remaining-flit count turns a data flit into a header, or the reverse, so the application stream goes out of order within a few flits.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int HDR_W = 28;
  localparam int LEN_W = 12;
  localparam int CU_W  = 12;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             sop;
    logic             eop;
    logic             co;
    logic             rsv;
    logic [CU_W-1:0]  cu;
  } fc_hdr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} tx_st_e;
endpackage

// File: rtl/fc_fifo.sv
module fc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/fc_tx.sv
module fc_tx
  import fc_pkg::*;
#(
  parameter int W         = 32,
  parameter int DCU       = 4,
  parameter int RX_DEPTH  = 16,
  parameter int TXB_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     app_data_i,
  input  logic             app_valid_i,
  input  logic             app_last_i,
  output logic             app_ready_o,
  output logic [W-1:0]     link_data_o,
  output logic             link_valid_o,
  input  logic             link_ready_i,
  input  logic             cu_valid_i,
  input  logic [CU_W-1:0]  cu_i,
  input  logic             freed_i
);
  localparam int SEG_W = $clog2(DCU + 1);
  localparam int CRD_W = $clog2(RX_DEPTH + 1);

  logic             d_full, d_empty, d_pop;
  logic [W-1:0]     d_dout;
  logic             s_full, s_empty, s_push, s_pop;
  logic [SEG_W:0]   s_dout;
  logic [SEG_W-1:0] seg_q, desc_len;
  logic             desc_eop, app_fire;

  assign app_ready_o = !d_full && !s_full;
  assign app_fire    = app_valid_i && app_ready_o;
  assign s_push      = app_fire && (app_last_i || seg_q == SEG_W'(DCU - 1));
  assign desc_len    = s_dout[SEG_W:1];
  assign desc_eop    = s_dout[0];

  fc_fifo #(.WIDTH(W), .DEPTH(TXB_DEPTH)) u_data (
    .clk_i, .rst_ni, .push_i(app_fire), .din_i(app_data_i), .full_o(d_full),
    .pop_i(d_pop), .dout_o(d_dout), .empty_o(d_empty));

  fc_fifo #(.WIDTH(SEG_W + 1), .DEPTH(TXB_DEPTH)) u_desc (
    .clk_i, .rst_ni, .push_i(s_push), .din_i({seg_q + SEG_W'(1), app_last_i}),
    .full_o(s_full), .pop_i(s_pop), .dout_o(s_dout), .empty_o(s_empty));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seg_q <= '0;
    else if (s_push)   seg_q <= '0;
    else if (app_fire) seg_q <= seg_q + SEG_W'(1);
  end

  tx_st_e           st_q;
  fc_hdr_t          hdr_q;
  logic [SEG_W-1:0] rem_q;
  logic [CRD_W-1:0] credit_q;
  logic [CU_W-1:0]  pend_q;
  logic             first_q;
  logic             launch_d, launch_c, link_fire;

  assign launch_d  = (st_q == ST_IDLE) && !s_empty && (credit_q >= CRD_W'(desc_len));
  assign launch_c  = (st_q == ST_IDLE) && !launch_d && (pend_q != '0);
  assign s_pop     = launch_d;
  assign link_fire = link_valid_o && link_ready_i;
  assign d_pop     = (st_q == ST_DATA) && link_ready_i;

  assign link_valid_o = (st_q != ST_IDLE);
  always_comb begin
    unique case (st_q)
      ST_HDR:  link_data_o = W'(hdr_q) << (W - HDR_W);
      ST_DATA: link_data_o = d_dout;
      default: link_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      hdr_q    <= '0;
      rem_q    <= '0;
      credit_q <= CRD_W'(RX_DEPTH);
      pend_q   <= '0;
      first_q  <= 1'b1;
    end else begin
      credit_q <= credit_q + (cu_valid_i ? CRD_W'(cu_i) : '0)
                           - (launch_d ? CRD_W'(desc_len) : '0);
      pend_q   <= ((launch_d || launch_c) ? '0 : pend_q) + CU_W'(freed_i);
      unique case (st_q)
        ST_IDLE: begin
          if (launch_d) begin
            hdr_q   <= '{len: LEN_W'(desc_len), sop: first_q, eop: desc_eop,
                         co: 1'b0, rsv: 1'b0, cu: pend_q};
            first_q <= desc_eop;
            st_q    <= ST_HDR;
          end else if (launch_c) begin
            hdr_q <= '{len: '0, sop: 1'b0, eop: 1'b0, co: 1'b1, rsv: 1'b0, cu: pend_q};
            st_q  <= ST_HDR;
          end
        end
        ST_HDR: if (link_fire) begin
          rem_q <= SEG_W'(hdr_q.len);
          st_q  <= (hdr_q.len == '0) ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (link_fire) begin
          rem_q <= rem_q - SEG_W'(1);
          if (rem_q == SEG_W'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  credit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CRD_W'(RX_DEPTH));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && !link_ready_i |=> link_valid_o && $stable(link_data_o));
  // R3
  data_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DATA |-> !d_empty);
endmodule

// File: rtl/fc_rx.sv
module fc_rx
  import fc_pkg::*;
#(
  parameter int W        = 32,
  parameter int RX_DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    link_data_i,
  input  logic            link_valid_i,
  output logic            link_ready_o,
  output logic [W-1:0]    app_data_o,
  output logic            app_valid_o,
  output logic            app_last_o,
  input  logic            app_ready_i,
  output logic            cu_valid_o,
  output logic [CU_W-1:0] cu_o,
  output logic            freed_o
);
  fc_hdr_t          hdr;
  logic [LEN_W-1:0] rem_q;
  logic             eop_q, is_hdr, fire, b_full, b_empty, b_push;
  logic [W:0]       b_dout;
  logic             unused_bits;

  assign hdr          = fc_hdr_t'(link_data_i[W-1 -: HDR_W]);
  assign unused_bits  = ^{link_data_i[W-HDR_W-1:0], hdr.sop, hdr.rsv};
  assign is_hdr       = (rem_q == '0);
  assign link_ready_o = is_hdr || !b_full;
  assign fire         = link_valid_i && link_ready_o;
  assign b_push       = fire && !is_hdr;
  assign cu_valid_o   = fire && is_hdr;
  assign cu_o         = hdr.cu;

  fc_fifo #(.WIDTH(W + 1), .DEPTH(RX_DEPTH)) u_buf (
    .clk_i, .rst_ni, .push_i(b_push),
    .din_i({eop_q && rem_q == LEN_W'(1), link_data_i}),
    .full_o(b_full), .pop_i(freed_o), .dout_o(b_dout), .empty_o(b_empty));

  assign app_valid_o = !b_empty;
  assign app_data_o  = b_dout[W-1:0];
  assign app_last_o  = b_dout[W];
  assign freed_o     = app_valid_o && app_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      eop_q <= 1'b0;
    end else if (fire) begin
      if (is_hdr) begin
        rem_q <= hdr.len;
        eop_q <= hdr.eop;
      end else begin
        rem_q <= rem_q - LEN_W'(1);
      end
    end
  end

  // R7
  co_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_valid_o && hdr.co |-> hdr.len == '0 && !hdr.eop);
  // R2
  data_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_push |=> rem_q == $past(rem_q) - LEN_W'(1));
endmodule

// File: rtl/link_credit_fc.sv
module link_credit_fc #(
  parameter int W         = 32,
  parameter int DCU       = 4,
  parameter int RX_DEPTH  = 16,
  parameter int TXB_DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] app_tx_data_i,
  input  logic         app_tx_valid_i,
  input  logic         app_tx_last_i,
  output logic         app_tx_ready_o,
  output logic [W-1:0] link_tx_data_o,
  output logic         link_tx_valid_o,
  input  logic         link_tx_ready_i,
  input  logic [W-1:0] link_rx_data_i,
  input  logic         link_rx_valid_i,
  output logic         link_rx_ready_o,
  output logic [W-1:0] app_rx_data_o,
  output logic         app_rx_valid_o,
  output logic         app_rx_last_o,
  input  logic         app_rx_ready_i
);
  logic                    cu_valid, freed;
  logic [fc_pkg::CU_W-1:0] cu;

  fc_tx #(.W(W), .DCU(DCU), .RX_DEPTH(RX_DEPTH), .TXB_DEPTH(TXB_DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .app_data_i(app_tx_data_i), .app_valid_i(app_tx_valid_i),
    .app_last_i(app_tx_last_i), .app_ready_o(app_tx_ready_o),
    .link_data_o(link_tx_data_o), .link_valid_o(link_tx_valid_o),
    .link_ready_i(link_tx_ready_i),
    .cu_valid_i(cu_valid), .cu_i(cu), .freed_i(freed));

  fc_rx #(.W(W), .RX_DEPTH(RX_DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .link_data_i(link_rx_data_i), .link_valid_i(link_rx_valid_i),
    .link_ready_o(link_rx_ready_o),
    .app_data_o(app_rx_data_o), .app_valid_o(app_rx_valid_o),
    .app_last_o(app_rx_last_o), .app_ready_i(app_rx_ready_i),
    .cu_valid_o(cu_valid), .cu_o(cu), .freed_o(freed));

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !link_tx_valid_o && !app_rx_valid_o);
endmodule

// File: tb/link_credit_fc_tb_top.sv
`timescale 1ns/1ps
module link_credit_fc_tb_top;
  localparam int W = 32, DCU = 4, RX_DEPTH = 16, TXB_DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] app_tx_data = '0, link_tx_data, link_rx_data, app_rx_data;
  logic app_tx_valid = 0, app_tx_last = 0, app_tx_ready;
  logic link_tx_valid, link_tx_ready, link_rx_valid, link_rx_ready;
  logic app_rx_valid, app_rx_last, app_rx_ready = 0, gate = 0;

  always #10 clk = ~clk;

  assign link_rx_data  = link_tx_data;
  assign link_rx_valid = link_tx_valid & gate;
  assign link_tx_ready = link_rx_ready & gate;

  link_credit_fc #(.W(W), .DCU(DCU), .RX_DEPTH(RX_DEPTH), .TXB_DEPTH(TXB_DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .app_tx_data_i(app_tx_data), .app_tx_valid_i(app_tx_valid),
    .app_tx_last_i(app_tx_last), .app_tx_ready_o(app_tx_ready),
    .link_tx_data_o(link_tx_data), .link_tx_valid_o(link_tx_valid),
    .link_tx_ready_i(link_tx_ready),
    .link_rx_data_i(link_rx_data), .link_rx_valid_i(link_rx_valid),
    .link_rx_ready_o(link_rx_ready),
    .app_rx_data_o(app_rx_data), .app_rx_valid_o(app_rx_valid),
    .app_rx_last_o(app_rx_last), .app_rx_ready_i(app_rx_ready));

  int checks = 0, errors = 0;
  logic [W:0] sb [0:8191];
  int msg_len [0:1023];
  int n_msgs = 0, total = 0, gen_msg = 0, gen_pos = 0, wr = 0, lk_rd = 0, rx_rd = 0;
  int p_rem = 0, cur_msg = 0, msg_rem = 0, hdr_data_sum = 0, link_data_cnt = 0;
  int cu_sum = 0, co_cnt = 0, tx_rate = 100, rx_rate = 100, gate_rate = 100;
  bit tx_have = 0, rx_hold = 0, hold_pend = 0;
  logic [W-1:0] hold_data;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int rem);
    return (rem < DCU) ? rem : DCU;
  endfunction

  task automatic add_msg(input int n);
    msg_len[n_msgs] = n;
    n_msgs++;
    total += n;
  endtask

  task automatic parse(input logic [W-1:0] d);
    int len, el, cu;
    bit sop, eop, co, nw;
    if (p_rem == 0) begin
      len = int'(d[W-1 -: 12]); sop = d[W-13]; eop = d[W-14]; co = d[W-15];
      cu = int'(d[W-17 -: 12]);
      chk(d[W-16] == 1'b0 && d[W-29:0] == '0, "R1 reserved/low bits", d[W-16], 0);
      cu_sum += cu;
      if (co) begin
        co_cnt++;
        chk(len == 0 && !sop && !eop, "R7 credit-only fields", len, 0);
      end else begin
        nw = (msg_rem == 0);
        if (nw) msg_rem = msg_len[cur_msg];
        el = exp_len(msg_rem);
        chk(len == el && len >= 1, "R2/R4 length", len, el);
        chk(sop == nw, "R4 start flag", sop, nw);
        chk(eop == (el == msg_rem), "R4 end flag", eop, el == msg_rem);
        chk(hdr_data_sum + len <= wr, "R3 store-and-forward", hdr_data_sum + len, wr);
        hdr_data_sum += len;
        msg_rem -= el;
        if (msg_rem == 0) cur_msg++;
        p_rem = len;
      end
    end else begin
      chk(d == sb[lk_rd][W-1:0], "R2 link payload", d, sb[lk_rd][W-1:0]);
      lk_rd++; link_data_cnt++; p_rem--;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!tx_have && gen_msg < n_msgs && int'($urandom % 100) < tx_rate) begin
      tx_have = 1;
      app_tx_data = $urandom;
      app_tx_last = (gen_pos == msg_len[gen_msg] - 1);
    end
    app_tx_valid = tx_have;
    app_rx_ready = rx_hold ? 1'b0 : (int'($urandom % 100) < rx_rate);
    gate = (int'($urandom % 100) < gate_rate);
    #1;
    if (hold_pend) chk(link_tx_valid && link_tx_data == hold_data, "R9 hold", link_tx_data, hold_data);
    hold_pend = link_tx_valid && !link_tx_ready;
    hold_data = link_tx_data;
    if (app_tx_valid && app_tx_ready) begin
      sb[wr] = {app_tx_last, app_tx_data}; wr++;
      tx_have = 0;
      if (app_tx_last) begin gen_pos = 0; gen_msg++; end
      else gen_pos++;
    end
    if (link_tx_valid && link_tx_ready) parse(link_tx_data);
    if (app_rx_valid && app_rx_ready) begin
      chk({app_rx_last, app_rx_data} == sb[rx_rd], "R8 rx order/last",
          {app_rx_last, app_rx_data}, sb[rx_rd]);
      rx_rd++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int co0, cu0, g;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    #1;
    // R10
    chk(!link_tx_valid && !app_rx_valid, "R10 valids in reset", link_tx_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!link_tx_valid && !app_rx_valid, "R10 valids after reset", app_rx_valid, 0);
    chk(app_tx_ready && link_rx_ready, "R10 readies after reset", app_tx_ready, 1);

    // R5: receiver never drains, credit caps the link
    rx_hold = 1;
    for (int i = 0; i < 6; i++) add_msg(2 * DCU);
    repeat (300) step();
    chk(link_data_cnt == RX_DEPTH, "R5 data flits with no credit return", link_data_cnt, RX_DEPTH);
    chk(!link_tx_valid, "R5 link idle at zero credit", link_tx_valid, 0);
    chk(cu_sum == 0 && co_cnt == 0, "R7 no credits while undrained", cu_sum, 0);

    // R6: random traffic with credit return
    rx_hold = 0; rx_rate = 70; gate_rate = 75; tx_rate = 80;
    for (int i = 0; i < 40; i++) add_msg(1 + int'($urandom % (3 * DCU + 1)));
    add_msg(DCU); add_msg(1); add_msg(DCU + 1);
    g = 0;
    while (rx_rd < total && g < 20000) begin step(); g++; end
    chk(rx_rd == total, "R6 all flits delivered", rx_rd, total);
    repeat (100) step();
    chk(cu_sum == rx_rd, "R7 credit sum equals drained flits", cu_sum, rx_rd);
    chk(!link_tx_valid, "R7 link quiet after drain", link_tx_valid, 0);

    // R7: credit-only packets when no data is waiting
    rx_hold = 1; gate_rate = 100; tx_rate = 100;
    add_msg(2 * DCU);
    repeat (100) step();
    co0 = co_cnt; cu0 = cu_sum;
    rx_hold = 0; rx_rate = 100;
    repeat (100) step();
    chk(co_cnt > co0, "R7 credit-only packet sent", co_cnt - co0, 1);
    chk(cu_sum - cu0 == 2 * DCU, "R7 returned credits", cu_sum - cu0, 2 * DCU);
    chk(rx_rd == total && hdr_data_sum == total, "R6 final totals", rx_rd, total);
    finish_run();
  end
endmodule